// File: doc/BRIEF.md
# Exposure Phase Sequencer

This block times a single exposure of a global-shutter pixel array. A start strobe begins the cycle. The block first holds every pixel in reset at once for a programmed length. It then counts a programmed integration time. For multi-slope operation it can fire up to two extra partial-reset pulses part-way through integration, which widens the dynamic range. When integration finishes it emits a one-cycle done strobe and returns to idle.

A single mode input sets the unit for every length. In one setting each length counts system clock cycles. In the other it counts pulses on a line-tick input, so the exposure follows the line timing of the array. Each length is a 16-bit value. Software writes it as a low byte and then a high byte into two consecutive 8-bit registers. The register file sits outside this block and presents the assembled values on its ports.

Top module: `expo_seq`

## Requirements
- R1: After reset, and whenever no exposure is running, `globalReset`, `slopeReset`, `integrating` and `done` are all low.
- R2: When `startPulse` is accepted, `globalReset` rises in the next cycle and stays high for exactly `resetLen` units.
- R3: `integrating` is high for exactly `intLen` units. It starts in the first cycle after `globalReset` falls, or in the first cycle after the accepted start when the reset phase is skipped.
- R4: `done` is high for exactly one cycle, the cycle after the last integration unit. The block is idle in the cycle after that.
- R5: A `resetLen` of zero skips the reset phase. An `intLen` of zero skips integration. With both at zero, `done` follows the accepted start directly.
- R6: With `lineMode`=1 a unit is one cycle in which `lineTick` is high, and every counter holds in cycles without a tick. With `lineMode`=0 a unit is one clock cycle and `lineTick` has no effect.
- R7: With `dsEnable`=1 and 1 ≤ `dsLen` ≤ `intLen`, `slopeReset` rises one cycle after the cycle in which the remaining integration units equal `dsLen`. It stays high for `slopeLen` units. It is cut off when integration ends.
- R8: `tsEnable` with `tsLen` gives a second partial-reset pulse by the same rule and independently of the first. A pulse that is triggered while another is still high restarts the full `slopeLen` width.
- R9: A `startPulse` that arrives while an exposure is running, including the done cycle, is ignored. The running sequence does not change and no new exposure follows.
- R10: No partial-reset pulse occurs when its enable is low, when its length is zero or larger than `intLen`, or when `slopeLen` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin an exposure; accepted only when idle |
| lineTick | input | 1 | One-cycle pulse per line period |
| lineMode | input | 1 | 1: count line ticks, 0: count clock cycles |
| dsEnable | input | 1 | Enable the first partial-reset pulse |
| tsEnable | input | 1 | Enable the second partial-reset pulse |
| resetLen | input | 16 | Global reset length in units |
| slopeLen | input | 16 | Width of each partial-reset pulse in units |
| intLen | input | 16 | Integration length in units |
| dsLen | input | 16 | Remaining integration at which the first pulse triggers |
| tsLen | input | 16 | Remaining integration at which the second pulse triggers |
| globalReset | output | 1 | All-pixel reset active |
| slopeReset | output | 1 | Partial-reset pulse active |
| integrating | output | 1 | Integration phase active |
| done | output | 1 | One-cycle end-of-exposure strobe |

## Verification
The hardest case to reach is two partial-reset triggers that overlap: the second trigger lands while the first pulse is still high, or lands in the same cycle as the last integration unit. The bench reaches these cases by sweeping the first trigger point, the second trigger point and the pulse width over every combination within a short integration. The expected pulse window is then the union of the two arithmetic windows, cut at the end of integration. Start strobes are also injected during integration and during the done cycle to show that they are dropped.

// File: rtl/expo_seq_pkg.sv
package expo_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GRST = 2'd1,
    ST_INT  = 2'd2,
    ST_DONE = 2'd3
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadRst;
    logic loadInt;
    logic inInt;
    logic clrPulse;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic cntLast;
    logic rstZero;
    logic intZero;
  } seqStatus_t;

endpackage

// File: rtl/expo_seq_dp.sv
module expo_seq_dp
  import expo_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             lineTick,
  input  logic             lineMode,
  input  logic             dsEnable,
  input  logic             tsEnable,
  input  logic [CNT_W-1:0] resetLen,
  input  logic [CNT_W-1:0] slopeLen,
  input  logic [CNT_W-1:0] intLen,
  input  logic [CNT_W-1:0] dsLen,
  input  logic [CNT_W-1:0] tsLen,
  output seqStatus_t       stat,
  output logic             slopeReset
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             tick;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] pulseCnt;
  logic             dsFired;
  logic             tsFired;
  logic             dsHit;
  logic             tsHit;

  // one unit of time: a clock cycle or a line tick
  assign tick = lineMode ? lineTick : 1'b1;

  // shared phase countdown, reloaded at each phase entry
  always_ff @(posedge clk) begin
    if (!rstN)                         phaseCnt <= ZERO;
    else if (strb.loadRst)             phaseCnt <= resetLen;
    else if (strb.loadInt)             phaseCnt <= intLen;
    else if (tick && phaseCnt != ZERO) phaseCnt <= phaseCnt - ONE;
  end

  assign stat.cntLast = tick && (phaseCnt == ONE);
  assign stat.rstZero = (resetLen == ZERO);
  assign stat.intZero = (intLen == ZERO);

  // trigger points: remaining integration equals the programmed mark
  assign dsHit = strb.inInt && dsEnable && !dsFired && (phaseCnt == dsLen);
  assign tsHit = strb.inInt && tsEnable && !tsFired && (phaseCnt == tsLen);

  always_ff @(posedge clk) begin
    if (!rstN || strb.loadInt) begin
      dsFired <= 1'b0;
      tsFired <= 1'b0;
    end else begin
      if (dsHit) dsFired <= 1'b1;
      if (tsHit) tsFired <= 1'b1;
    end
  end

  // partial-reset pulse width counter, runs alongside integration
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrPulse)        pulseCnt <= ZERO;
    else if (dsHit || tsHit)           pulseCnt <= slopeLen;
    else if (tick && pulseCnt != ZERO) pulseCnt <= pulseCnt - ONE;
  end

  assign slopeReset = (pulseCnt != ZERO);

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strb.loadRst && !strb.loadInt) |=> (phaseCnt == $past(phaseCnt)));

  // R7
  slope_in_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCnt != ZERO) |-> strb.inInt);

  // R8
  pulse_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dsHit || tsHit) && !strb.clrPulse) |=> (pulseCnt == $past(slopeLen)));

endmodule

// File: rtl/expo_seq_ctrl.sv
module expo_seq_ctrl
  import expo_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       globalReset,
  output logic       integrating,
  output logic       done
);

  seqState_t state, nextState;

  always_comb begin
    nextState     = state;
    strb.loadRst  = 1'b0;
    strb.loadInt  = 1'b0;
    strb.clrPulse = 1'b0;
    unique case (state)
      ST_IDLE: if (startPulse) begin
        if (!stat.rstZero) begin
          nextState    = ST_GRST;
          strb.loadRst = 1'b1;
        end else if (!stat.intZero) begin
          nextState    = ST_INT;
          strb.loadInt = 1'b1;
        end else begin
          nextState    = ST_DONE;
        end
      end
      ST_GRST: if (stat.cntLast) begin
        if (stat.intZero) nextState = ST_DONE;
        else begin
          nextState    = ST_INT;
          strb.loadInt = 1'b1;
        end
      end
      ST_INT: if (stat.cntLast) begin
        nextState     = ST_DONE;
        strb.clrPulse = 1'b1;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign strb.inInt = (state == ST_INT);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign globalReset = (state == ST_GRST);
  assign integrating = (state == ST_INT);
  assign done        = (state == ST_DONE);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE));

  // R9
  grst_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT || state == ST_DONE) |=> (state != ST_GRST));

  // R2
  grst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GRST && !stat.cntLast) |=> (state == ST_GRST));

  // R3
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT && !stat.cntLast) |=> (state == ST_INT));

endmodule

// File: rtl/expo_seq.sv
module expo_seq
  import expo_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             lineTick,
  input  logic             lineMode,
  input  logic             dsEnable,
  input  logic             tsEnable,
  input  logic [CNT_W-1:0] resetLen,
  input  logic [CNT_W-1:0] slopeLen,
  input  logic [CNT_W-1:0] intLen,
  input  logic [CNT_W-1:0] dsLen,
  input  logic [CNT_W-1:0] tsLen,
  output logic             globalReset,
  output logic             slopeReset,
  output logic             integrating,
  output logic             done
);

  seqStrobe_t strb;
  seqStatus_t stat;

  expo_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .stat        (stat),
    .strb        (strb),
    .globalReset (globalReset),
    .integrating (integrating),
    .done        (done)
  );

  expo_seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lineTick   (lineTick),
    .lineMode   (lineMode),
    .dsEnable   (dsEnable),
    .tsEnable   (tsEnable),
    .resetLen   (resetLen),
    .slopeLen   (slopeLen),
    .intLen     (intLen),
    .dsLen      (dsLen),
    .tsLen      (tsLen),
    .stat       (stat),
    .slopeReset (slopeReset)
  );

endmodule

// File: tb/expo_seq_tb.sv
module expo_seq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic lineTick = 1'b0;
  logic lineMode = 1'b0;
  logic dsEnable = 1'b0;
  logic tsEnable = 1'b0;
  logic [15:0] resetLen = '0;
  logic [15:0] slopeLen = '0;
  logic [15:0] intLen = '0;
  logic [15:0] dsLen = '0;
  logic [15:0] tsLen = '0;
  logic globalReset, slopeReset, integrating, done;

  int errors = 0;
  int checks = 0;
  int gcyc = 0;

  always #2 clk = ~clk;

  expo_seq u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lineTick(lineTick),
    .lineMode(lineMode), .dsEnable(dsEnable), .tsEnable(tsEnable),
    .resetLen(resetLen), .slopeLen(slopeLen), .intLen(intLen),
    .dsLen(dsLen), .tsLen(tsLen), .globalReset(globalReset),
    .slopeReset(slopeReset), .integrating(integrating), .done(done)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, gcyc, act, exp);
    end
  endtask

  // expected partial-reset window for one trigger, i = integration unit index
  function automatic bit inWin(int i, int il, bit en, int mark, int sl);
    if (!en || mark < 1 || mark > il) return 1'b0;
    return (i >= il - mark + 1) && (i <= il - mark + sl);
  endfunction

  // one exposure; period 0 = clock mode, otherwise line ticks every period cycles
  task automatic runExpo(input int rl, input int il, input int period,
                         input bit dsE, input int dsL, input bit tsE, input int tsL,
                         input int sl, input int injectAt);
    int tot = rl + il;
    int n = (period == 0) ? tot + 2 : period * tot + period + 2;
    int tcnt = 0;
    int tprev = -1;
    bit tk;
    bit expS;
    int i;
    @(negedge clk);
    resetLen = 16'(rl); intLen = 16'(il); slopeLen = 16'(sl);
    dsLen = 16'(dsL); tsLen = 16'(tsL); dsEnable = dsE; tsEnable = tsE;
    lineMode = (period != 0);
    startPulse = 1'b1;
    lineTick = (period != 0) ? (gcyc % period == 0) : gcyc[0];
    @(negedge clk); gcyc++;
    startPulse = 1'b0;
    for (int c = 0; c <= n; c++) begin
      i = tcnt - rl;
      chk(globalReset, tcnt < rl, "R2", "globalReset");
      chk(integrating, (tcnt >= rl) && (tcnt < tot), "R3", "integrating");
      chk(done, (tcnt == tot) && (c == 0 || tprev < tot), (tot == 0) ? "R5" : "R4", "done");
      expS = (tcnt < tot) && (inWin(i, il, dsE, dsL, sl) || inWin(i, il, tsE, tsL, sl));
      if (period == 0) chk(slopeReset, expS, (dsE || tsE) ? "R8" : "R10", "slopeReset");
      else chk(slopeReset, 1'b0, "R6", "slopeReset");
      startPulse = (c == injectAt);
      lineTick = (period != 0) ? (gcyc % period == 0) : gcyc[0];
      tk = (period != 0) ? lineTick : 1'b1;
      @(negedge clk); gcyc++;
      tprev = tcnt;
      if (tcnt <= tot) tcnt += int'(tk);
    end
    startPulse = 1'b0;
    // R1 / R9: idle afterwards, nothing restarted
    chk(globalReset | integrating | done | slopeReset, 1'b0, "R9", "idle after run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(globalReset, 1'b0, "R1", "globalReset");
    chk(integrating, 1'b0, "R1", "integrating");
    chk(done, 1'b0, "R1", "done");
    chk(slopeReset, 1'b0, "R1", "slopeReset");

    // R2 R3 R4 R5: clock-mode length sweep, start injected while busy (R9)
    for (int rl = 0; rl <= 3; rl++)
      for (int il = 0; il <= 5; il++)
        runExpo(rl, il, 0, 0, 0, 0, 0, 0, (il >= 2) ? rl + 1 : rl + il);

    // R7 R8 R10: partial-reset trigger and width sweep
    for (int d = 0; d <= 7; d++)
      for (int t = 0; t <= 3; t++)
        for (int s = 0; s <= 3; s++)
          runExpo(1, 6, 0, 1, d, 1, t, s, -1);

    // R7: first pulse only; R10: enables low with marks set
    runExpo(2, 5, 0, 1, 3, 0, 2, 2, -1);
    runExpo(2, 5, 0, 0, 3, 0, 2, 2, -1);

    // R6: line-tick mode sweep
    for (int rl = 0; rl <= 2; rl++)
      for (int il = 0; il <= 3; il++)
        runExpo(rl, il, 3, 0, 0, 0, 0, 0, rl);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule